// File: doc/BRIEF.md
# Universal Bidirectional Bus Register

This block is an 18-bit data path between two buses, A and B. Each direction has its own storage stage and its own set of controls: a latch-enable, a capture clock and an output-enable. In each direction the data can flow straight through, be held, or be captured on a clock edge. For synthesis, each bus is split into separate input, output and output-enable signals. The high-impedance state of a real pad shows up here as a deasserted enable.

Each direction has a single storage element. While its latch-enable is high, the output follows the live input through a multiplexer, and the storage is left alone. While latch-enable is low, the output shows the stored word. That word changes only on a falling edge of the direction's capture clock, which loads the live input. The A-to-B enable is active high. The B-to-A enable is active low. An asynchronous active-low reset clears both stores.

Top module: `ubr_top`

## Requirements
- R1: Each direction carries 18 bits, and the two directions are independent: activity in one never changes the other direction's output.
- R2: With a2b_le high, b_out equals a_in with no clock involved, including when a_in changes.
- R3: With a2b_le low and a2b_clk steady, b_out keeps the stored word while a_in changes.
- R4: With a2b_le low, a falling edge of a2b_clk stores a_in, and b_out shows that word from then on.
- R5: Falling edges of a2b_clk while a2b_le is high leave the store unchanged. This is visible as the old word once a2b_le drops.
- R6: Lowering a2b_le loads nothing: b_out switches from the live input to the last captured word.
- R7: b_oe equals a2b_oe (1 = drive). The enable has no effect on b_out's data value in any mode.
- R8: The B-to-A direction obeys R2 to R7 using b_in, a_out, b2a_le and b2a_clk. Its enable is active low: a_oe = 1 exactly when b2a_oe_n = 0.
- R9: While rst_n is low, both stores are cleared to zero, so with latch-enable low both outputs read zero after reset.
- R10: A rising edge of a capture clock stores nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset of both stores |
| a_in | input | 18 | Data received from bus A |
| a_out | output | 18 | Data to drive onto bus A (B-to-A path) |
| a_oe | output | 1 | 1 = drive a_out onto bus A |
| a2b_le | input | 1 | A-to-B latch-enable, 1 = pass live data |
| a2b_clk | input | 1 | A-to-B capture clock, loads on falling edge |
| a2b_oe | input | 1 | A-to-B output enable, active high |
| b_in | input | 18 | Data received from bus B |
| b_out | output | 18 | Data to drive onto bus B (A-to-B path) |
| b_oe | output | 1 | 1 = drive b_out onto bus B |
| b2a_le | input | 1 | B-to-A latch-enable, 1 = pass live data |
| b2a_clk | input | 1 | B-to-A capture clock, loads on falling edge |
| b2a_oe_n | input | 1 | B-to-A output enable, active low |

## Verification
Every output is due in the same delta as its cause. Transparent data, enable decoding and the switch to the stored word when latch-enable drops all settle combinationally. A capture is due right after the falling edge of the direction's own clock. The bench moves a single control or data input per step, on the falling edge of its own 100 MHz timing clock, and reads the outputs 2 ns later. No result depends on which process runs first at an edge. Capture data is always applied one step before the capture-clock fall, so the word stored is unambiguous.

// File: rtl/ubr_pkg.sv
package ubr_pkg;
  localparam int unsigned DEF_WIDTH = 18;
  localparam int unsigned NUM_DIRS  = 2;

  typedef enum logic {DIR_A2B = 1'b0, DIR_B2A = 1'b1} dir_e;

  // Turn a raw enable pin into "drive" according to its polarity.
  function automatic logic drive_enable(input logic ctl, input bit active_low);
    return active_low ? ~ctl : ctl;
  endfunction
endpackage

// File: rtl/ubr_store.sv
module ubr_store #(
  parameter int unsigned WIDTH = ubr_pkg::DEF_WIDTH
) (
  input  logic             rst_n,
  input  logic             cap_clk,
  input  logic             le,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  // A load is permitted only while the transparent path is not selected.
  logic load_ok;
  assign load_ok = ~le;

  always_ff @(negedge cap_clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (load_ok) q <= d;
  end

  a_r4_capture: assert property (@(negedge cap_clk) disable iff (!rst_n)
    !le |=> (q == $past(d)));

  a_r5_no_load_le_high: assert property (@(negedge cap_clk) disable iff (!rst_n)
    le |=> $stable(q));

  a_r9_reset_clear: assert property (@(posedge rst_n) disable iff (!rst_n)
    1'b1 |-> (q == '0));
endmodule

// File: rtl/ubr_lane.sv
module ubr_lane #(
  parameter int unsigned WIDTH         = ubr_pkg::DEF_WIDTH,
  parameter bit          OE_ACTIVE_LOW = 1'b0
) (
  input  logic             rst_n,
  input  logic             cap_clk,
  input  logic             le,
  input  logic             oe_ctl,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             dout_en
);
  function automatic logic [WIDTH-1:0] path_select(
    input logic le_i, input logic [WIDTH-1:0] live, input logic [WIDTH-1:0] kept);
    return le_i ? live : kept;
  endfunction

  logic [WIDTH-1:0] held;
  logic             pass_live;

  ubr_store #(.WIDTH(WIDTH)) u_store (
    .rst_n  (rst_n),
    .cap_clk(cap_clk),
    .le     (le),
    .d      (din),
    .q      (held)
  );

  assign pass_live = le;
  assign dout      = path_select(pass_live, din, held);
  assign dout_en   = ubr_pkg::drive_enable(oe_ctl, OE_ACTIVE_LOW);

  // Two consecutive low-enable capture edges: the output shows the earlier word.
  a_r4_out_shows_capture: assert property (@(negedge cap_clk) disable iff (!rst_n)
    !le ##1 !le |-> (dout == $past(din)));
endmodule

// File: rtl/ubr_top.sv
module ubr_top #(
  parameter int unsigned WIDTH = ubr_pkg::DEF_WIDTH
) (
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic             a2b_le,
  input  logic             a2b_clk,
  input  logic             a2b_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe,
  input  logic             b2a_le,
  input  logic             b2a_clk,
  input  logic             b2a_oe_n
);
  localparam int unsigned ND = ubr_pkg::NUM_DIRS;

  logic [WIDTH-1:0] lane_din  [ND];
  logic [WIDTH-1:0] lane_dout [ND];
  logic             lane_le   [ND];
  logic             lane_clk  [ND];
  logic             lane_oe   [ND];
  logic             lane_en   [ND];

  assign lane_din[ubr_pkg::DIR_A2B] = a_in;
  assign lane_le [ubr_pkg::DIR_A2B] = a2b_le;
  assign lane_clk[ubr_pkg::DIR_A2B] = a2b_clk;
  assign lane_oe [ubr_pkg::DIR_A2B] = a2b_oe;
  assign lane_din[ubr_pkg::DIR_B2A] = b_in;
  assign lane_le [ubr_pkg::DIR_B2A] = b2a_le;
  assign lane_clk[ubr_pkg::DIR_B2A] = b2a_clk;
  assign lane_oe [ubr_pkg::DIR_B2A] = b2a_oe_n;

  for (genvar d = 0; d < ND; d++) begin : g_lane
    ubr_lane #(
      .WIDTH        (WIDTH),
      .OE_ACTIVE_LOW(d == int'(ubr_pkg::DIR_B2A))
    ) u_lane (
      .rst_n  (rst_n),
      .cap_clk(lane_clk[d]),
      .le     (lane_le[d]),
      .oe_ctl (lane_oe[d]),
      .din    (lane_din[d]),
      .dout   (lane_dout[d]),
      .dout_en(lane_en[d])
    );
  end

  assign b_out = lane_dout[ubr_pkg::DIR_A2B];
  assign b_oe  = lane_en [ubr_pkg::DIR_A2B];
  assign a_out = lane_dout[ubr_pkg::DIR_B2A];
  assign a_oe  = lane_en [ubr_pkg::DIR_B2A];
endmodule

// File: tb/ubr_top_tb.sv
`timescale 1ns/1ps
module ubr_top_tb;
  localparam int W = 18;
  localparam logic [W-1:0] MASK = '1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic a_oe, b_oe, a2b_le, a2b_clk, a2b_oe, b2a_le, b2a_clk, b2a_oe_n;

  ubr_top #(.WIDTH(W)) u_dut (
    .rst_n(rst_n), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .a2b_le(a2b_le), .a2b_clk(a2b_clk), .a2b_oe(a2b_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .b2a_le(b2a_le), .b2a_clk(b2a_clk), .b2a_oe_n(b2a_oe_n)
  );

  int checks = 0;
  int failures = 0;
  logic [W-1:0] exp_store [2];
  logic [W-1:0] cur_data  [2];

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic string tg(input int d, input string rq);
    return (d == 0) ? rq : {rq, "/R8"};
  endfunction

  function automatic logic [W-1:0] out_of(input int d);
    return (d == 0) ? b_out : a_out;
  endfunction

  function automatic logic [W-1:0] en_of(input int d);
    return (d == 0) ? {{(W-1){1'b0}}, b_oe} : {{(W-1){1'b0}}, a_oe};
  endfunction

  task automatic set_le(input int d, input logic v);
    @(negedge clk); if (d == 0) a2b_le = v; else b2a_le = v; #2;
  endtask
  task automatic set_clk(input int d, input logic v);
    @(negedge clk); if (d == 0) a2b_clk = v; else b2a_clk = v; #2;
  endtask
  task automatic set_data(input int d, input logic [W-1:0] v);
    @(negedge clk); if (d == 0) a_in = v; else b_in = v; cur_data[d] = v; #2;
  endtask
  task automatic set_en(input int d, input logic drive);
    @(negedge clk); if (d == 0) a2b_oe = drive; else b2a_oe_n = ~drive; #2;
  endtask

  task automatic capture(input int d, input logic [W-1:0] v);
    set_data(d, v);
    set_clk(d, 1'b0);
    exp_store[d] = v;
    set_clk(d, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    a_in = '1; b_in = '1; cur_data[0] = '1; cur_data[1] = '1;
    a2b_le = 1'b0; b2a_le = 1'b0; a2b_clk = 1'b1; b2a_clk = 1'b1;
    a2b_oe = 1'b1; b2a_oe_n = 1'b0;
    exp_store[0] = '0; exp_store[1] = '0;
    repeat (3) @(negedge clk);
    #2;
    check("R9 reset b_out", b_out, '0);
    check("R9 reset a_out", a_out, '0);
    @(negedge clk); rst_n = 1'b1; #2;
    check("R9 after release b_out", b_out, '0);
    check("R9 after release a_out", a_out, '0);

    for (int d = 0; d < 2; d++) begin
      // R2 transparent walk
      set_le(d, 1'b1);
      for (int i = 0; i < W; i++) begin
        logic [W-1:0] v;
        v = {{(W-1){1'b0}}, 1'b1} << i;
        set_data(d, v);
        check(tg(d, "R2 walk1"), out_of(d), v);
        set_data(d, ~v);
        check(tg(d, "R2 walk0"), out_of(d), ~v);
      end
      // R5: clock falls while transparent must not store
      set_data(d, 18'h3C0F3);
      set_clk(d, 1'b0);
      set_clk(d, 1'b1);
      set_le(d, 1'b0);
      check(tg(d, "R5 no load while le high"), out_of(d), exp_store[d]);
      // R4/R3/R10 capture sweep
      for (int i = 0; i < W; i++) begin
        logic [W-1:0] v;
        v = (W'(i) * 18'h2D3B + W'(d) * 18'h1F0F) ^ (W'(i) << 3) ^ 18'h24924;
        set_data(d, v);
        set_clk(d, 1'b0);
        exp_store[d] = v;
        check(tg(d, "R4 capture"), out_of(d), v);
        set_data(d, ~v & MASK);
        check(tg(d, "R3 hold clk low"), out_of(d), v);
        set_clk(d, 1'b1);
        check(tg(d, "R10 rising edge no load"), out_of(d), v);
        set_data(d, v ^ 18'h15555);
        check(tg(d, "R3 hold clk high"), out_of(d), v);
      end
      // R6: latch-enable fall loads nothing
      capture(d, 18'h2A5C3);
      set_le(d, 1'b1);
      set_data(d, 18'h1B7E0);
      check(tg(d, "R2 live after le rise"), out_of(d), 18'h1B7E0);
      set_le(d, 1'b0);
      check(tg(d, "R6 le fall shows last capture"), out_of(d), 18'h2A5C3);
      // R7 enable decoding, independent of data mode
      for (int en = 0; en < 2; en++) begin
        for (int le = 0; le < 2; le++) begin
          set_en(d, en[0]);
          set_le(d, le[0]);
          check(tg(d, "R7 enable"), en_of(d), {{(W-1){1'b0}}, en[0]});
          check(tg(d, "R7 data unaffected"), out_of(d),
                le[0] ? cur_data[d] : exp_store[d]);
        end
      end
      set_en(d, 1'b1);
      set_le(d, 1'b0);
      // R1: the other direction is untouched
      check("R1 other direction b_out", b_out, exp_store[0]);
      check("R1 other direction a_out", a_out, exp_store[1]);
    end

    // R1: simultaneous opposite activity
    capture(0, 18'h0F0F0);
    check("R1 a2b capture vs b2a", a_out, exp_store[1]);
    capture(1, 18'h30303);
    check("R1 b2a capture vs a2b", b_out, 18'h0F0F0);
    check("R1 b2a own capture", a_out, 18'h30303);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule